// File: doc/BRIEF.md
# Keyed Non-Volatile Array Program and Erase Controller

This block is a register-mapped controller for a small on-chip non-volatile array, held here as an array of flip-flops. Software places a target word index in an address register, a value in a data register, and an operation code plus a write-enable bit in a control register. It then writes a three-value key sequence and sets the start bit. The start bit reads back high for as long as the operation runs, and software polls it until it drops.

Two operations exist. A word program ANDs the data into the stored word, so programming can only turn ones into zeros. A page erase returns every word of the addressed page to all ones. A lock register marks pages as protected. An operation aimed at a protected page sets a write-error flag and leaves the array alone. A low-voltage input aborts a running operation and sets a low-voltage error flag. Completing the key sequence arms exactly one start, and the armed state lapses after `ARM_WINDOW` cycles.

The unlock state machine has four states. `U_IDLE` goes to `U_GOT0` on a zero key. `U_GOT0` goes to `U_GOT1` on 0xAA996655. `U_GOT1` goes to `U_ARMED` on 0x556699AA. From `U_IDLE`, `U_GOT0` and `U_GOT1`, any other key value returns the machine to `U_IDLE`. `U_ARMED` returns to `U_IDLE` on an accepted start, on any key write, or when the window expires. The sequencer has three states. `SQ_IDLE` goes to `SQ_CHECK` on an accepted start. `SQ_CHECK` goes to `SQ_RUN` for a valid operation on an unprotected page with good voltage; otherwise it goes back to `SQ_IDLE`. `SQ_RUN` counts down the latency and then goes to `SQ_IDLE`, either after committing the result or when low voltage aborts it.

Top module: `nvm_keyed_ctrl`

## Requirements
- R1: After reset the control register reads 0, the lock register reads 0, and every array word reads all ones.
- R2: `bus_addr[4:2]` selects the register: 0 control, 1 key, 2 address, 3 data, 4 lock, 5 array window (read-only; returns the word at the address register). `bus_addr[1:0]` selects the write alias: 0 replaces the register, 1 ORs in the written ones, 2 clears the written ones, 3 is ignored. Reads ignore the alias.
- R3: The control register fields are: opcode in bits [3:0], low-voltage error in bit 12, write error in bit 13, write enable in bit 14, start/busy in bit 15. All other bits read 0.
- R4: Only raw-alias key writes of 0x00000000, then 0xAA996655, then 0x556699AA, in that order, arm the controller. Any other value resets the sequence, and key writes through the set or clear alias are ignored. A start while not armed is ignored, leaves the array unchanged, and the start bit stays low.
- R5: A start is accepted only if write enable was already set before the start write. Clearing write enable through the clear alias blocks later operations.
- R6: An accepted start consumes the arming, so a second start needs a new key sequence. Arming expires after `ARM_WINDOW` cycles: a start written on the `ARM_WINDOW`-th cycle after the last key is accepted, and one written a cycle later is ignored.
- R7: Opcode 1 ANDs the data register into the addressed word. The start bit reads high for `WRITE_LAT`+1 cycles.
- R8: Opcode 4 sets every word of the page `addr[ADDR_W-1:OFF_W]` to all ones and leaves other pages unchanged. The start bit reads high for `ERASE_LAT`+1 cycles.
- R9: An operation with opcode 1 or 4 aimed at a page whose lock bit is set sets the write-error flag, leaves the array unchanged, and is busy for 1 cycle.
- R10: `lv_low` high while an operation is busy aborts it on the next edge, sets the low-voltage error flag, and leaves the array unchanged.
- R11: Any opcode other than 1 or 4 completes after 1 busy cycle with no change to the array.
- R12: Error flags can be cleared by software but never set by it. Software cannot clear the start bit while an operation is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Register select [4:2] and alias [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the selected register |
| lv_low | input | 1 | Low-voltage condition, aborts a running operation |

## Verification
The assertions assume that `bus_wr` is a clean single-cycle strobe and that `lv_low` changes only between clock edges. They also assume that no software clear of an error flag lands on the same edge as a hardware abort, because hardware wins that edge. The directed tasks drive all inputs at the falling edge and apply at most one write per cycle. They raise `lv_low` only while an operation is already running, and they clear error flags only when the controller is idle, so every stimulus stays inside these assumptions.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int BUS_W = 32;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 32'h0000_0000;
    localparam logic [BUS_W-1:0] KEY_SECOND = 32'hAA99_6655;
    localparam logic [BUS_W-1:0] KEY_THIRD  = 32'h5566_99AA;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_WRITE = 4'd1;
    localparam logic [3:0] OP_ERASE = 4'd4;

    localparam int CB_START = 15;
    localparam int CB_WREN  = 14;
    localparam int CB_WRERR = 13;
    localparam int CB_LVERR = 12;

    typedef enum logic [2:0] {
        RS_CTRL  = 3'd0,
        RS_KEY   = 3'd1,
        RS_ADDR  = 3'd2,
        RS_DATA  = 3'd3,
        RS_LOCK  = 3'd4,
        RS_ARRAY = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        AL_RAW  = 2'd0,
        AL_SET  = 2'd1,
        AL_CLR  = 2'd2,
        AL_NONE = 2'd3
    } alias_e;

    function automatic logic [BUS_W-1:0] apply_alias(
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] wd,
        input alias_e           al
    );
        logic [BUS_W-1:0] res;
        unique case (al)
            AL_RAW:  res = wd;
            AL_SET:  res = cur | wd;
            AL_CLR:  res = cur & ~wd;
            default: res = cur;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
#(
    parameter int ARM_WINDOW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [BUS_W-1:0] key_val,
    input  logic             consume,
    output logic             armed
);
    localparam int TMR_W = $clog2(ARM_WINDOW + 1);

    typedef enum logic [1:0] {
        U_IDLE  = 2'd0,
        U_GOT0  = 2'd1,
        U_GOT1  = 2'd2,
        U_ARMED = 2'd3
    } ulk_e;

    ulk_e             state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             expired;

    assign expired = (tmr_q == TMR_W'(ARM_WINDOW - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE:  if (key_wr) state_d = (key_val == KEY_FIRST)  ? U_GOT0  : U_IDLE;
            U_GOT0:  if (key_wr) state_d = (key_val == KEY_SECOND) ? U_GOT1  : U_IDLE;
            U_GOT1:  if (key_wr) state_d = (key_val == KEY_THIRD)  ? U_ARMED : U_IDLE;
            U_ARMED: if (consume || key_wr || expired) state_d = U_IDLE;
            default: state_d = U_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (state_q == U_ARMED && state_d == U_ARMED) begin
            tmr_q <= tmr_q + 1'b1;
        end else begin
            tmr_q <= '0;
        end
    end

    assign armed = (state_q == U_ARMED);
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int PAGES     = 8,
    parameter int ADDR_W    = 5,
    parameter int OFF_W     = 2,
    parameter int WRITE_LAT = 6,
    parameter int ERASE_LAT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [3:0]        launch_op,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [BUS_W-1:0]  launch_data,
    input  logic [PAGES-1:0]  lock,
    input  logic              lv_low,
    output logic              busy,
    output logic              commit_we,
    output logic              commit_erase,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [BUS_W-1:0]  commit_data,
    output logic              set_wrerr,
    output logic              set_lverr
);
    localparam int CNT_W  = $clog2(ERASE_LAT + 1);
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_CHECK = 2'd1,
        SQ_RUN   = 2'd2
    } seq_e;

    seq_e              state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [3:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  data_q;
    logic              op_valid, page_locked, cnt_zero;
    logic [PAGE_W-1:0] page;

    assign page        = addr_q[ADDR_W-1:OFF_W];
    assign op_valid    = (op_q == OP_WRITE) || (op_q == OP_ERASE);
    assign page_locked = lock[page];
    assign cnt_zero    = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (launch) state_d = SQ_CHECK;
            SQ_CHECK: begin
                if (lv_low || !op_valid || page_locked) state_d = SQ_IDLE;
                else                                    state_d = SQ_RUN;
            end
            SQ_RUN:   if (lv_low || cnt_zero) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            addr_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (state_q == SQ_IDLE && launch) begin
                op_q   <= launch_op;
                addr_q <= launch_addr;
                data_q <= launch_data;
            end
            if (state_q == SQ_CHECK) begin
                cnt_q <= (op_q == OP_ERASE) ? CNT_W'(ERASE_LAT - 1) : CNT_W'(WRITE_LAT - 1);
            end else if (state_q == SQ_RUN && !cnt_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy         = (state_q != SQ_IDLE);
        commit_we    = (state_q == SQ_RUN) && cnt_zero && !lv_low;
        commit_erase = (op_q == OP_ERASE);
        commit_addr  = addr_q;
        commit_data  = data_q;
        set_lverr    = (state_q != SQ_IDLE) && lv_low;
        set_wrerr    = (state_q == SQ_CHECK) && !lv_low && op_valid && page_locked;
    end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_we,
    input  logic              commit_erase,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [BUS_W-1:0]  commit_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int WORDS  = 1 << ADDR_W;
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [BUS_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
        logic page_hit, word_hit;
        assign page_hit = (commit_addr[ADDR_W-1:OFF_W] == WADDR[ADDR_W-1:OFF_W]);
        assign word_hit = (commit_addr == WADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[w] <= '1;
            end else if (commit_we && commit_erase && page_hit) begin
                mem[w] <= '1;
            end else if (commit_we && !commit_erase && word_hit) begin
                mem[w] <= mem[w] & commit_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_keyed_ctrl.sv
module nvm_keyed_ctrl
    import nvm_pkg::*;
#(
    parameter int PAGES          = 8,
    parameter int WORDS_PER_PAGE = 4,
    parameter int WRITE_LAT      = 6,
    parameter int ERASE_LAT      = 20,
    parameter int ARM_WINDOW     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        lv_low
);
    localparam int OFF_W  = $clog2(WORDS_PER_PAGE);
    localparam int PAGE_W = $clog2(PAGES);
    localparam int ADDR_W = PAGE_W + OFF_W;

    reg_sel_e          sel;
    alias_e            al;
    logic              wr_ctrl, key_wr, accept;
    logic [BUS_W-1:0]  ctrl_cur, ctrl_nv;
    logic [3:0]        opcode_q;
    logic              wren_q, wrerr_q, lverr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  data_q;
    logic [PAGES-1:0]  lock_q;
    logic              armed, busy;
    logic              commit_we, commit_erase, set_wrerr, set_lverr;
    logic [ADDR_W-1:0] commit_addr;
    logic [BUS_W-1:0]  commit_data, arr_rd;

    assign sel = reg_sel_e'(bus_addr[4:2]);
    assign al  = alias_e'(bus_addr[1:0]);

    always_comb begin
        ctrl_cur                = '0;
        ctrl_cur[3:0]           = opcode_q;
        ctrl_cur[CB_LVERR]      = lverr_q;
        ctrl_cur[CB_WRERR]      = wrerr_q;
        ctrl_cur[CB_WREN]       = wren_q;
        ctrl_cur[CB_START]      = busy;
        ctrl_nv                 = apply_alias(ctrl_cur, bus_wdata, al);
        wr_ctrl                 = bus_wr && (sel == RS_CTRL) && (al != AL_NONE);
        key_wr                  = bus_wr && (sel == RS_KEY) && (al == AL_RAW);
        accept                  = wr_ctrl && ctrl_nv[CB_START] && !busy && wren_q && armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q <= OP_NOP;
            wren_q   <= 1'b0;
            wrerr_q  <= 1'b0;
            lverr_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                opcode_q <= ctrl_nv[3:0];
                wren_q   <= ctrl_nv[CB_WREN];
            end
            if (set_wrerr)    wrerr_q <= 1'b1;
            else if (wr_ctrl) wrerr_q <= wrerr_q & ctrl_nv[CB_WRERR];
            if (set_lverr)    lverr_q <= 1'b1;
            else if (wr_ctrl) lverr_q <= lverr_q & ctrl_nv[CB_LVERR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            lock_q <= '0;
        end else if (bus_wr && al != AL_NONE) begin
            unique case (sel)
                RS_ADDR: addr_q <= ADDR_W'(apply_alias(BUS_W'(addr_q), bus_wdata, al));
                RS_DATA: data_q <= apply_alias(data_q, bus_wdata, al);
                RS_LOCK: lock_q <= PAGES'(apply_alias(BUS_W'(lock_q), bus_wdata, al));
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            RS_CTRL:  bus_rdata = ctrl_cur;
            RS_ADDR:  bus_rdata = BUS_W'(addr_q);
            RS_DATA:  bus_rdata = data_q;
            RS_LOCK:  bus_rdata = BUS_W'(lock_q);
            RS_ARRAY: bus_rdata = arr_rd;
            default:  bus_rdata = '0;
        endcase
    end

    nvm_unlock #(
        .ARM_WINDOW (ARM_WINDOW)
    ) i_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (bus_wdata),
        .consume (accept),
        .armed   (armed)
    );

    nvm_seq #(
        .PAGES     (PAGES),
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .WRITE_LAT (WRITE_LAT),
        .ERASE_LAT (ERASE_LAT)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (accept),
        .launch_op    (ctrl_nv[3:0]),
        .launch_addr  (addr_q),
        .launch_data  (data_q),
        .lock         (lock_q),
        .lv_low       (lv_low),
        .busy         (busy),
        .commit_we    (commit_we),
        .commit_erase (commit_erase),
        .commit_addr  (commit_addr),
        .commit_data  (commit_data),
        .set_wrerr    (set_wrerr),
        .set_lverr    (set_lverr)
    );

    nvm_array #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_we    (commit_we),
        .commit_erase (commit_erase),
        .commit_addr  (commit_addr),
        .commit_data  (commit_data),
        .rd_addr      (addr_q),
        .rd_data      (arr_rd)
    );
endmodule

// File: rtl/nvm_keyed_ctrl_chk.sv
module nvm_keyed_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic key_wr,
    input logic armed,
    input logic wren,
    input logic busy,
    input logic commit_we,
    input logic wrerr,
    input logic lverr,
    input logic lv_low
);
    p_arm_after_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_wr))
        else $error("armed without a key write");

    p_start_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(armed) && $past(wren)))
        else $error("operation began without arming and write enable");

    p_arm_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !armed)
        else $error("arming survived an accepted start");

    p_commit_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |=> !busy)
        else $error("still busy after commit");

    p_wrerr_from_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrerr) |-> $past(busy))
        else $error("write error raised outside an operation");

    p_lv_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lv_low) |=> (!busy && lverr))
        else $error("low voltage did not abort");

    p_no_commit_lv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |-> !lv_low)
        else $error("commit under low voltage");
endmodule

bind nvm_keyed_ctrl nvm_keyed_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .armed     (armed),
    .wren      (wren_q),
    .busy      (busy),
    .commit_we (commit_we),
    .wrerr     (wrerr_q),
    .lverr     (lverr_q),
    .lv_low    (lv_low)
);

// File: tb/test_nvm_keyed_ctrl.sv
`timescale 1ns/1ps
module test_nvm_keyed_ctrl;
    localparam int WLAT = 6;
    localparam int ELAT = 20;
    localparam int WIN  = 8;
    localparam logic [2:0] S_CTRL = 3'd0, S_KEY = 3'd1, S_ADDR = 3'd2,
                           S_DATA = 3'd3, S_LOCK = 3'd4, S_ARR = 3'd5;
    localparam logic [1:0] A_RAW = 2'd0, A_SET = 2'd1, A_CLR = 2'd2, A_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lv_low = 1'b0;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2.5 clk = ~clk;

    nvm_keyed_ctrl #(
        .WRITE_LAT  (WLAT),
        .ERASE_LAT  (ELAT),
        .ARM_WINDOW (WIN)
    ) i_nvm_keyed_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lv_low    (lv_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = {s, a}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        bus_addr = {s, 2'b00};
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_word(input int idx, output logic [31:0] d);
        wr(S_ADDR, A_RAW, 32'(idx));
        rd(S_ARR, d);
    endtask

    task automatic unlock();
        wr(S_KEY, A_RAW, 32'h0000_0000);
        wr(S_KEY, A_RAW, 32'hAA99_6655);
        wr(S_KEY, A_RAW, 32'h5566_99AA);
    endtask

    task automatic go();
        wr(S_CTRL, A_SET, 32'h8000);
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] c;
        n = 0;
        rd(S_CTRL, c);
        while (c[15] && n < 1000) begin
            n++;
            @(negedge clk);
            rd(S_CTRL, c);
        end
    endtask

    task automatic prep(input int idx, input logic [31:0] d, input logic [31:0] ctrl);
        wr(S_ADDR, A_RAW, 32'(idx));
        wr(S_DATA, A_RAW, d);
        wr(S_CTRL, A_RAW, ctrl);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(S_CTRL, v);  check("R1 ctrl", v, 32'h0);
        rd(S_LOCK, v);  check("R1 lock", v, 32'h0);
        rd(S_ARR, v);   check("R1 word0", v, 32'hFFFF_FFFF);
        rd_word(31, v); check("R1 word31", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(S_ADDR, A_RAW, 32'h05);   rd(S_ADDR, v); check("R2 addr raw", v, 32'h05);
        wr(S_ADDR, A_SET, 32'h10);   rd(S_ADDR, v); check("R2 addr set", v, 32'h15);
        wr(S_ADDR, A_CLR, 32'h01);   rd(S_ADDR, v); check("R2 addr clr", v, 32'h14);
        wr(S_ADDR, A_NONE, 32'h1F);  rd(S_ADDR, v); check("R2 alias3 ignored", v, 32'h14);
        wr(S_DATA, A_RAW, 32'hF0F0); wr(S_DATA, A_SET, 32'h000F); wr(S_DATA, A_CLR, 32'hF000);
        rd(S_DATA, v); check("R2 data set/clr", v, 32'h00FF);
    endtask

    task automatic t_word();
        logic [31:0] v;
        int n;
        prep(5, 32'h1234_5678, 32'h4001);
        rd(S_CTRL, v); check("R3 ctrl fields", v, 32'h4001);
        unlock(); go(); wait_idle(n);
        check("R7 write busy cycles", 32'(n), 32'(WLAT + 1));
        rd_word(5, v); check("R7 first program", v, 32'h1234_5678);
        wr(S_DATA, A_RAW, 32'hFF00_FF00);
        unlock(); go(); wait_idle(n);
        rd_word(5, v); check("R7 program only clears bits", v, 32'h1200_5600);
    endtask

    task automatic t_erase();
        logic [31:0] v;
        int n;
        prep(8, 32'h0, 32'h4001);
        unlock(); go(); wait_idle(n);
        prep(6, 32'h0, 32'h4004);
        unlock(); go(); wait_idle(n);
        check("R8 erase busy cycles", 32'(n), 32'(ELAT + 1));
        rd_word(5, v); check("R8 page word erased", v, 32'hFFFF_FFFF);
        rd_word(8, v); check("R8 other page kept", v, 32'h0);
    endtask

    task automatic t_keys();
        logic [31:0] v;
        prep(10, 32'h0, 32'h4001);
        wr(S_KEY, A_RAW, 32'h0); wr(S_KEY, A_RAW, 32'h5566_99AA); wr(S_KEY, A_RAW, 32'hAA99_6655);
        go(); rd(S_CTRL, v); check("R4 wrong order ignored", 32'(v[15]), 32'h0);
        wr(S_KEY, A_RAW, 32'h0); wr(S_KEY, A_RAW, 32'hAA99_6655); wr(S_KEY, A_RAW, 32'h1);
        wr(S_KEY, A_RAW, 32'h5566_99AA);
        go(); rd(S_CTRL, v); check("R4 bad key resets", 32'(v[15]), 32'h0);
        wr(S_KEY, A_RAW, 32'h0); wr(S_KEY, A_SET, 32'hAA99_6655); wr(S_KEY, A_RAW, 32'h5566_99AA);
        go(); rd(S_CTRL, v); check("R4 set-alias key ignored", 32'(v[15]), 32'h0);
        rd_word(10, v); check("R4 array unchanged", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_wren();
        logic [31:0] v;
        prep(10, 32'h0, 32'h4001);
        wr(S_CTRL, A_CLR, 32'h4000);
        rd(S_CTRL, v); check("R5 wren cleared", v, 32'h0001);
        unlock(); go();
        rd(S_CTRL, v); check("R5 start without wren", 32'(v[15]), 32'h0);
        repeat (WIN + 2) @(negedge clk);
        rd_word(10, v); check("R5 array unchanged", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_arm();
        logic [31:0] v;
        int n;
        prep(9, 32'hFFFF_FFFE, 32'h4001);
        unlock(); repeat (WIN - 1) @(negedge clk); go(); wait_idle(n);
        check("R6 start at window edge", 32'(n), 32'(WLAT + 1));
        rd_word(9, v); check("R6 accepted op", v, 32'hFFFF_FFFE);
        wr(S_DATA, A_RAW, 32'h0);
        go(); rd(S_CTRL, v); check("R6 arming consumed", 32'(v[15]), 32'h0);
        unlock(); repeat (WIN) @(negedge clk); go();
        rd(S_CTRL, v); check("R6 arming expired", 32'(v[15]), 32'h0);
        rd_word(9, v); check("R6 array unchanged", v, 32'hFFFF_FFFE);
    endtask

    task automatic t_protect();
        logic [31:0] v;
        int n;
        wr(S_LOCK, A_RAW, 32'h4);
        prep(9, 32'h0, 32'h4001);
        unlock(); go(); wait_idle(n);
        check("R9 locked busy cycles", 32'(n), 32'h1);
        rd(S_CTRL, v); check("R9 wrerr set", v, 32'h6001);
        rd_word(9, v); check("R9 word unchanged", v, 32'hFFFF_FFFE);
        prep(8, 32'h0, 32'h6004);
        unlock(); go(); wait_idle(n);
        rd_word(8, v); check("R9 erase blocked", v, 32'h0);
        wr(S_CTRL, A_SET, 32'h1000); rd(S_CTRL, v); check("R12 set cannot raise flag", v, 32'h6004);
        wr(S_CTRL, A_CLR, 32'h2000); rd(S_CTRL, v); check("R12 clear alias clears flag", v, 32'h4004);
        wr(S_LOCK, A_RAW, 32'h0);
    endtask

    task automatic t_lowv();
        logic [31:0] v;
        int n;
        prep(12, 32'h0, 32'h4001);
        unlock(); go();
        repeat (2) @(negedge clk);
        lv_low = 1'b1;
        @(negedge clk);
        rd(S_CTRL, v); check("R10 abort with flag", v, 32'h5001);
        lv_low = 1'b0;
        rd_word(12, v); check("R10 array unchanged", v, 32'hFFFF_FFFF);
        wr(S_CTRL, A_RAW, 32'h4001); rd(S_CTRL, v); check("R12 raw write clears flag", v, 32'h4001);
        prep(0, 32'h0, 32'h4004);
        unlock(); go();
        wr(S_CTRL, A_CLR, 32'h8000);
        rd(S_CTRL, v); check("R12 start not clearable", 32'(v[15]), 32'h1);
        wait_idle(n);
    endtask

    task automatic t_nop();
        logic [31:0] v;
        int n;
        prep(1, 32'h0, 32'h4000);
        unlock(); go(); wait_idle(n);
        check("R11 nop busy cycles", 32'(n), 32'h1);
        wr(S_CTRL, A_RAW, 32'h4002);
        unlock(); go(); wait_idle(n);
        check("R11 undefined op busy cycles", 32'(n), 32'h1);
        rd_word(1, v); check("R11 array unchanged", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alias();
        t_word();
        t_erase();
        t_keys();
        t_wren();
        t_arm();
        t_protect();
        t_lowv();
        t_nop();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule